// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim/Complete Handshake

This block gathers level-sensitive interrupt lines from a parameterised set of sources and presents one request line to a single processor context. Each source has a small priority level, an enable bit and a latched pending flag. A programmable threshold masks out low-priority sources, and the controller keeps a registered record of the best eligible source.

Software services interrupts with a claim/complete handshake. Reading the claim register returns the ID of the chosen source and clears its pending flag. That source then stays blocked until software writes the same ID back to the same register. Reading the claim register again after a completion lets an interrupt handler chain to the next waiting source without leaving the handler. ID 0 is reserved and means "nothing to service".

Top module: `pirq_ctrl`

## Requirements
- R1: Each source n (1 ≤ n < NSRC) has a 3-bit priority word at byte offset 4·n. Only bits [2:0] are stored, and the upper bits read as zero. Offset 0 (source 0) and IDs at or above NSRC read as zero and ignore writes.
- R2: Pending flags read from offset 0x1000 + 4·(n/32), with source n at bit n%32. Bus writes to these words have no effect.
- R3: Enable bits use the same packing from offset 0x2000 and are read/write. The bit for source 0 always reads as 0.
- R4: A source is eligible when it is pending, enabled, has a nonzero priority and has a priority at or above the 3-bit threshold at offset 0x200000. `irq_o` is high exactly when some source is eligible.
- R5: A read of offset 0x200004 returns the eligible source with the highest priority. Among equal priorities the lowest ID wins. The read returns 0 when no source is eligible.
- R6: A claim read that returns a nonzero ID clears that source's pending flag and marks the source as claimed.
- R7: While a source is claimed, its input cannot set its pending flag. Once the source is completed, an input that is still high sets the flag again.
- R8: A write of an ID to offset 0x200004 completes that source. The write is ignored when the ID is not enabled or not currently claimed.
- R9: Read data appears on `bus_rdata_o` in the cycle after the read strobe. A claim uses the winner registered in the previous cycle, and returns 0 if that winner is no longer eligible, so two back-to-back claim reads yield the ID and then 0.
- R10: After reset, all priorities, enables, pending flags, claims and the threshold are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level interrupt inputs; bit 0 is ignored |
| bus_rd_i | input | 1 | Read strobe, one access per cycle |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Request to the processor context |

## Verification
The assertions assume that read and write strobes never occur in the same cycle, and that a complete write names an ID below NSRC whenever enable state is checked against it. The bench issues exactly one bus operation at a time and places idle cycles between operations. Its completion IDs come either from its own list of claimed sources or from a random value in range, so the assumptions hold. Input lines change only between operations, which keeps the bench's step-by-step model aligned with the registered selection.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PRIO_W    = 3;
  localparam int WORD_BITS = 32;
  localparam int PEND_AREA = 1;          // offset 0x1000 >> 12
  localparam int EN_AREA   = 2;          // offset 0x2000 >> 12
  localparam int THR_OFS   = 32'h200000;
  localparam int CLAIM_OFS = 32'h200004;

  function automatic int word_of(input int id);
    return id / WORD_BITS;
  endfunction

  function automatic int bit_of(input int id);
    return id % WORD_BITS;
  endfunction

  // Eligibility rule shared by every source slot.
  function automatic logic can_fire(input logic pend, input logic en,
                                    input logic [PRIO_W-1:0] prio,
                                    input logic [PRIO_W-1:0] thr);
    return pend && en && (prio != '0) && (prio >= thr);
  endfunction
endpackage

// File: rtl/pirq_gate.sv
module pirq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic claimed_o
);
  logic pend_q, claimed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      claimed_q <= 1'b0;
    end else if (claim_i) begin
      pend_q    <= 1'b0;
      claimed_q <= 1'b1;
    end else begin
      if (done_i && claimed_q) claimed_q <= 1'b0;
      if (src_i && !claimed_q) pend_q <= 1'b1;
    end
  end

  assign pend_o    = pend_q;
  assign claimed_o = claimed_q;

  a_r7_no_repend: assert property (@(posedge clk) disable iff (!rst_n)
    claimed_q |-> !pend_q);
  a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (!pend_q && claimed_q));
  a_r8_done_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !claimed_q && !claim_i) |=> !claimed_q);
endmodule

// File: rtl/pirq_select.sv
module pirq_select #(
  parameter int NSRC = 64,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NSRC-1:0]                      elig_i,
  input  logic [NSRC-1:0][pirq_pkg::PRIO_W-1:0] prio_i,
  output logic [IDW-1:0]                       win_o,
  output logic                                 any_o
);
  logic [IDW-1:0]                  best_id;
  logic [pirq_pkg::PRIO_W-1:0]     best_p;
  logic [IDW-1:0]                  win_q;

  // Ascending scan with strict compare keeps the lowest ID on ties.
  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int n = 1; n < NSRC; n++) begin
      if (elig_i[n] && (prio_i[n] > best_p)) begin
        best_id = IDW'(n);
        best_p  = prio_i[n];
      end
    end
  end

  assign any_o = |elig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= best_id;
  end

  assign win_o = win_q;

  a_r5_win_needs_elig: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> $past(any_o));
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  import pirq_pkg::*;
  localparam int IDW = $clog2(NSRC);
  localparam int AW  = ADDR_W - 12;

  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NSRC-1:0]             en_q;
  logic [PRIO_W-1:0]           thr_q;
  logic [NSRC-1:0]             pend, claimed, elig, claim_vec, done_vec;
  logic [IDW-1:0]              win, grant_id;
  logic                        any_elig;
  logic [31:0]                 rd_val, rdata_q;

  // Address decode
  logic [AW-1:0] area;
  logic [9:0]    slot;
  logic          hit_prio, hit_pend, hit_en, hit_thr, hit_claim;
  logic          claim_fire, done_wr, done_id_ok;

  assign area      = bus_addr_i[ADDR_W-1:12];
  assign slot      = bus_addr_i[11:2];
  assign hit_prio  = (area == '0) && (bus_addr_i[1:0] == 2'b00);
  assign hit_pend  = (area == AW'(PEND_AREA)) && (bus_addr_i[1:0] == 2'b00);
  assign hit_en    = (area == AW'(EN_AREA)) && (bus_addr_i[1:0] == 2'b00);
  assign hit_thr   = (bus_addr_i == ADDR_W'(THR_OFS));
  assign hit_claim = (bus_addr_i == ADDR_W'(CLAIM_OFS));

  assign claim_fire = bus_rd_i && hit_claim;
  assign done_wr    = bus_wr_i && hit_claim;
  assign done_id_ok = bus_wdata_i < 32'(NSRC);

  // A stale winner that lost eligibility yields no grant.
  assign grant_id = ((win != '0) && elig[win]) ? win : '0;

  // Per-source gateways and eligibility
  for (genvar n = 0; n < NSRC; n++) begin : g_src
    assign elig[n]      = (n != 0) && can_fire(pend[n], en_q[n], prio_q[n], thr_q);
    assign claim_vec[n] = claim_fire && (n != 0) && (grant_id == IDW'(n));
    assign done_vec[n]  = done_wr && done_id_ok && (n != 0) &&
                          (bus_wdata_i[IDW-1:0] == IDW'(n)) && en_q[n];
    pirq_gate i_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i[n] && (n != 0)),
      .claim_i  (claim_vec[n]),
      .done_i   (done_vec[n]),
      .pend_o   (pend[n]),
      .claimed_o(claimed[n])
    );
  end

  pirq_select #(.NSRC(NSRC)) i_select (
    .clk   (clk),
    .rst_n (rst_n),
    .elig_i(elig),
    .prio_i(prio_q),
    .win_o (win),
    .any_o (any_elig)
  );

  assign irq_o = any_elig;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_wr_i) begin
      for (int n = 1; n < NSRC; n++) begin
        if (hit_prio && (int'(slot) == n)) prio_q[n] <= bus_wdata_i[PRIO_W-1:0];
        if (hit_en && (int'(slot) == word_of(n))) en_q[n] <= bus_wdata_i[bit_of(n)];
      end
      if (hit_thr) thr_q <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (hit_claim) rd_val = 32'(grant_id);
    else if (hit_thr) rd_val = 32'(thr_q);
    else begin
      for (int n = 1; n < NSRC; n++) begin
        if (hit_prio && (int'(slot) == n)) rd_val = 32'(prio_q[n]);
        if (hit_pend && (int'(slot) == word_of(n))) rd_val[bit_of(n)] = pend[n];
        if (hit_en && (int'(slot) == word_of(n))) rd_val[bit_of(n)] = en_q[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;

  a_r8_done_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && done_id_ok && !bus_rd_i && !en_q[bus_wdata_i[IDW-1:0]])
      |=> $stable(claimed));
  a_r4_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & en_q) != '0));
  a_r10_src0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !claimed[0]);
endmodule

// File: tb/test_pirq_ctrl.sv
module test_pirq_ctrl;
  localparam int NSRC = 64;
  localparam int CLAIM = 32'h200004;
  localparam int THR   = 32'h200000;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src = '0;
  logic rd = 0, wr = 0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int nchk = 0, nfail = 0;

  // Reference state
  int m_prio [NSRC];
  bit m_en [NSRC], m_pend [NSRC], m_clm [NSRC];
  int m_thr = 0;

  always #2.5 clk = ~clk;

  pirq_ctrl #(.NSRC(NSRC)) i_pirq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_elig(input int n);
    return n != 0 && m_pend[n] && m_en[n] && m_prio[n] != 0 && m_prio[n] >= m_thr;
  endfunction

  function automatic int m_best();
    int b = 0, bp = 0;
    for (int n = 1; n < NSRC; n++)
      if (m_elig(n) && m_prio[n] > bp) begin b = n; bp = m_prio[n]; end
    return b;
  endfunction

  function automatic bit m_any();
    for (int n = 1; n < NSRC; n++) if (m_elig(n)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_pword(input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) v[b] = m_pend[w*32+b];
    return v;
  endfunction

  function automatic logic [31:0] m_eword(input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) v[b] = m_en[w*32+b];
    return v;
  endfunction

  task automatic m_tick();
    for (int n = 1; n < NSRC; n++) if (src[n] && !m_clm[n]) m_pend[n] = 1;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    m_tick();
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr = 1; addr = 22'(a); wdata = d;
    @(negedge clk);
    wr = 0;
    settle();
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    rd = 1; addr = 22'(a);
    @(negedge clk);
    d = rdata; rd = 0;
    settle();
  endtask

  task automatic w_prio(input int n, input logic [31:0] v);
    bus_write(4*n, v);
    if (n > 0 && n < NSRC) m_prio[n] = int'(v[2:0]);
  endtask

  task automatic w_en(input int w, input logic [31:0] v);
    bus_write(32'h2000 + 4*w, v);
    for (int b = 0; b < 32; b++) if (w*32+b != 0) m_en[w*32+b] = v[b];
  endtask

  task automatic w_thr(input int t);
    bus_write(THR, 32'(t));
    m_thr = t & 7;
  endtask

  task automatic set_src(input logic [NSRC-1:0] s);
    @(negedge clk);
    src = s;
    settle();
  endtask

  task automatic do_claim(output int id);
    logic [31:0] d;
    bus_read(CLAIM, d);
    id = int'(d);
  endtask

  task automatic claim_check(input string req);
    int exp, got;
    exp = m_best();
    do_claim(got);
    chk(got == exp, req, got, exp);
    if (exp != 0) begin m_pend[exp] = 0; m_clm[exp] = 1; m_tick(); end
  endtask

  task automatic do_complete(input int id);
    bus_write(CLAIM, 32'(id));
    if (id > 0 && id < NSRC && m_en[id] && m_clm[id]) begin
      m_clm[id] = 0;
      settle();
    end
  endtask

  task automatic pend_check(input int w, input string req);
    logic [31:0] d;
    bus_read(32'h1000 + 4*w, d);
    chk(d == m_pword(w), req, d, m_pword(w));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int id, r1, r2;
    void'($urandom(32'd20240611));
    for (int n = 0; n < NSRC; n++) begin
      m_prio[n] = 0; m_en[n] = 0; m_pend[n] = 0; m_clm[n] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk(irq == 0, "R10 irq after reset", irq, 0);
    bus_read(4*7, d);       chk(d == 0, "R10 prio after reset", d, 0);
    bus_read(THR, d);       chk(d == 0, "R10 threshold after reset", d, 0);
    pend_check(0, "R10 pending after reset");
    claim_check("R5 empty claim after reset");

    // R1 priority storage and upper bits
    w_prio(5, 32'hFFFF_FFF3);
    bus_read(4*5, d);       chk(d == 3, "R1 upper bits read zero", d, 3);
    w_prio(0, 32'h7);
    bus_read(0, d);         chk(d == 0, "R1 source 0 slot", d, 0);
    w_prio(9, 3); w_prio(40, 6);

    // R3 enable packing, bit 0 fixed
    w_en(0, 32'hFFFF_FFFF); w_en(1, 32'hFFFF_FFFF);
    bus_read(32'h2000, d);  chk(d == 32'hFFFF_FFFE, "R3 source 0 enable bit", d, 32'hFFFF_FFFE);
    bus_read(32'h2004, d);  chk(d == 32'hFFFF_FFFF, "R3 second enable word", d, 32'hFFFF_FFFF);

    // R4/R5 tie resolves to lowest ID
    set_src((64'd1 << 9) | (64'd1 << 5) | 64'd1);
    chk(irq == 1, "R4 irq with eligible source", irq, 1);
    bus_read(32'h1000, d);  chk(d == 32'h220, "R2 pending packing", d, 32'h220);
    do_claim(id); chk(id == 5, "R5 tie goes to lowest ID", id, 5);
    m_pend[5] = 0; m_clm[5] = 1;
    bus_read(32'h1000, d);  chk(d == 32'h200, "R6 claim clears pending", d, 32'h200);
    do_claim(id); chk(id == 9, "R5 next claim", id, 9);
    m_pend[9] = 0; m_clm[9] = 1;
    bus_read(32'h1000, d);  chk(d == 0, "R7 claimed sources stay clear", d, 0);
    chk(irq == 0, "R4 irq low with nothing pending", irq, 0);

    // R8 ignored completions
    w_en(0, 32'hFFFF_FDFF);
    do_complete(9);
    w_en(0, 32'hFFFF_FFFF);
    bus_read(32'h1000, d);  chk(d == 0, "R8 completion of disabled ID ignored", d, 0);
    do_complete(7);
    bus_read(32'h1000, d);  chk(d == 0, "R8 completion of unclaimed ID ignored", d, 0);
    do_complete(9);
    bus_read(32'h1000, d);  chk(d == 32'h200, "R7 re-pend after completion", d, 32'h200);

    // R4 threshold boundaries and priority zero
    w_thr(4);
    chk(irq == 0, "R4 below threshold", irq, 0);
    do_claim(id); chk(id == 0, "R5 claim below threshold", id, 0);
    w_thr(3);
    chk(irq == 1, "R4 equal to threshold", irq, 1);
    w_prio(9, 0);
    chk(irq == 0, "R4 priority zero never fires", irq, 0);
    w_prio(9, 3);

    // R2 pending is read-only
    bus_write(32'h1000, 32'h0);
    pend_check(0, "R2 write to pending ignored");

    // R9 back-to-back claims
    set_src((64'd1 << 40) | (64'd1 << 9));
    @(negedge clk);
    rd = 1; addr = 22'(CLAIM);
    @(negedge clk); r1 = int'(rdata);
    @(negedge clk); r2 = int'(rdata);
    rd = 0;
    m_pend[40] = 0; m_clm[40] = 1;
    settle();
    chk(r1 == 40, "R9 first back-to-back claim", r1, 40);
    chk(r2 == 0, "R9 stale winner yields zero", r2, 0);
    do_complete(40); do_complete(5);
    claim_check("R5 claim after chain");

    // Constrained random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0: begin
          int n = $urandom_range(0, NSRC - 1);
          logic [31:0] v = $urandom;
          w_prio(n, v);
          bus_read(4*n, d);
          chk(d == 32'(m_prio[n]), "R1 random priority readback", d, m_prio[n]);
        end
        1: begin
          int w = $urandom_range(0, 1);
          logic [31:0] v = $urandom | $urandom;
          w_en(w, v);
          bus_read(32'h2000 + 4*w, d);
          chk(d == m_eword(w), "R3 random enable readback", d, m_eword(w));
        end
        2: w_thr($urandom_range(0, 7));
        3: set_src({$urandom, $urandom} & {$urandom, $urandom});
        4: claim_check("R5 random claim");
        5: begin
          int cid = $urandom_range(0, NSRC - 1);
          for (int n = 1; n < NSRC; n++) if (m_clm[n] && $urandom_range(0, 1) == 1) cid = n;
          do_complete(cid);
        end
        default: begin
          int w = $urandom_range(0, 1);
          bus_write(32'h1000 + 4*w, $urandom);
          pend_check(w, "R2 random pending read");
        end
      endcase
      chk(irq == m_any(), "R4 random irq level", irq, m_any());
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule